// File: doc/BRIEF.md
# Context-Tagged Fully Associative Address Translation Buffer

The block translates a 43-bit virtual address into a 40-bit physical address. It holds a parameterised number of entries (48 by default) and compares every entry against the incoming address at once. Each entry records a virtual page number, a physical frame number, a 7-bit context number and a 2-bit size code. The size code lets one entry cover a naturally aligned run of 1, 8, 64 or 512 base pages of 8 KB each. The address bits inside that run are left out of the compare and are carried unchanged into the physical address.

A lookup presented at a clock edge produces a registered hit or miss, with the physical address, on the next cycle. A miss handler loads translations through the fill port. A fill goes to the lowest-numbered empty slot. When no slot is empty, it goes to a round-robin slot that is never the slot which produced the most recent hit. A single-cycle flush empties the whole table, for example on a context wrap.

Top module: `va_xlat_tlb`

## Requirements
- R1: After reset no entry is valid, so every lookup misses and `lk_hit`, `lk_miss` and `lk_pa` are 0 until a lookup is made.
- R2: A lookup sampled with `lk_valid`=1 at an edge raises exactly one of `lk_hit` or `lk_miss` for the following cycle. A cycle with `lk_valid`=0 leaves both low in the following cycle.
- R3: An entry matches when all three hold: it is valid, its context number equals `lk_asn`, and its stored page number equals `lk_va[42:13]` on every bit at or above bit 3*S of the page number, where S is the entry's size code. A context mismatch gives a miss.
- R4: On a hit, `lk_pa[12:0]` equals `lk_va[12:0]`. `lk_pa[13+3*S-1:13]` equals the same bits of `lk_va`. The remaining bits of `lk_pa[39:13]` come from the stored frame number. On a miss, `lk_pa` is 0.
- R5: Size code S = 0, 1, 2 or 3 makes one entry cover 1, 8, 64 or 512 pages (8 KB, 64 KB, 512 KB or 4 MB). An address one page beyond that range misses.
- R6: While any entry is invalid, a fill writes the lowest-numbered invalid entry and leaves the replacement pointer unchanged.
- R7: When all entries are valid, a fill replaces the entry at the replacement pointer. The pointer starts at 0 after reset. After each such fill it moves to the slot after the one replaced, wrapping from ENTRIES-1 to 0.
- R8: The slot that produced the most recent hit is never replaced while the table is full; the slot after it is taken instead. A hit in the same cycle as the fill counts as the most recent hit.
- R9: When several entries match one lookup, the lowest-numbered one supplies the translation.
- R10: `inv_all` clears every valid bit in one cycle and forgets the most recent hit. A fill in the same cycle is discarded.
- R11: A lookup made in the same cycle as a fill or flush sees the table as it stood before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_va | input | VA_W (43) | Virtual address to translate |
| lk_asn | input | ASN_W (7) | Current context number |
| lk_hit | output | 1 | Registered: previous lookup hit |
| lk_miss | output | 1 | Registered: previous lookup missed |
| lk_pa | output | PA_W (40) | Registered translated address, 0 unless hit |
| fl_valid | input | 1 | Write a new translation this cycle |
| fl_vpn | input | VA_W-13 (30) | Virtual page number of the new entry |
| fl_pfn | input | PA_W-13 (27) | Physical frame number of the new entry |
| fl_asn | input | ASN_W (7) | Context number of the new entry |
| fl_size | input | 2 | Size code: 0..3 for 1, 8, 64 or 512 pages |
| inv_all | input | 1 | Flush all entries |

## Verification
A stale valid bit or a wrong stored page number shows up as a wrong hit, miss or physical address one cycle after the next lookup of an affected address. A replacement pointer that drifts from the round-robin rule stays hidden until the table is full. From then on it evicts the wrong slot, and that surfaces only when the evicted or surviving translation is looked up. For that reason the bench keeps a full reference table and looks up recently filled and recently hit pages soon after every replacement. A wrong most-recent-hit record surfaces the same way, as a lost translation for the page that was hit just before the fill.

// File: rtl/va_xlat_tlb.sv
module va_xlat_tlb #(
  parameter int VA_W    = 43,
  parameter int PA_W    = 40,
  parameter int ASN_W   = 7,
  parameter int ENTRIES = 48
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lk_valid,
  input  logic [VA_W-1:0]       lk_va,
  input  logic [ASN_W-1:0]      lk_asn,
  output logic                  lk_hit,
  output logic                  lk_miss,
  output logic [PA_W-1:0]       lk_pa,
  input  logic                  fl_valid,
  input  logic [VA_W-14:0]      fl_vpn,
  input  logic [PA_W-14:0]      fl_pfn,
  input  logic [ASN_W-1:0]      fl_asn,
  input  logic [1:0]            fl_size,
  input  logic                  inv_all
);
  localparam int PG    = 13;
  localparam int VPN_W = VA_W - PG;
  localparam int PFN_W = PA_W - PG;
  localparam int MW    = 9;
  localparam int IDX_W = $clog2(ENTRIES);

  function automatic logic [MW-1:0] size_mask(input logic [1:0] s);
    case (s)
      2'd0:    return 9'h000;
      2'd1:    return 9'h007;
      2'd2:    return 9'h03F;
      default: return 9'h1FF;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] next_slot(input logic [IDX_W-1:0] x);
    return (x == IDX_W'(ENTRIES - 1)) ? '0 : x + 1'b1;
  endfunction

  logic [ENTRIES-1:0] vld;
  logic [VPN_W-1:0]   e_vpn [ENTRIES];
  logic [PFN_W-1:0]   e_pfn [ENTRIES];
  logic [ASN_W-1:0]   e_asn [ENTRIES];
  logic [1:0]         e_sz  [ENTRIES];

  logic [ENTRIES-1:0] match;
  logic [IDX_W-1:0]   hit_idx, first_free, ptr, lh_idx, eff_lh, rr_victim, victim;
  logic               any_hit, any_free, lh_v, eff_lh_v, lk_take;
  logic [PFN_W-1:0]   pa_mask, pa_pfn;

  wire [VPN_W-1:0] lk_vpn = lk_va[VA_W-1:PG];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    wire [VPN_W-1:0] ign = {{(VPN_W-MW){1'b0}}, size_mask(e_sz[i])};
    assign match[i] = vld[i] && (e_asn[i] == lk_asn) &&
                      (((e_vpn[i] ^ lk_vpn) & ~ign) == '0);
  end

  always_comb begin
    hit_idx    = '0;
    first_free = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
      if (!vld[i])  first_free = IDX_W'(i);
    end
  end

  assign any_hit   = |match;
  assign any_free  = ~&vld;
  assign lk_take   = lk_valid && any_hit;
  assign pa_mask   = {{(PFN_W-MW){1'b0}}, size_mask(e_sz[hit_idx])};
  assign pa_pfn    = (e_pfn[hit_idx] & ~pa_mask) | (lk_va[PG +: PFN_W] & pa_mask);

  assign eff_lh_v  = lk_take || lh_v;
  assign eff_lh    = lk_take ? hit_idx : lh_idx;
  assign rr_victim = (eff_lh_v && ptr == eff_lh) ? next_slot(ptr) : ptr;
  assign victim    = any_free ? first_free : rr_victim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lk_hit  <= 1'b0;
      lk_miss <= 1'b0;
      lk_pa   <= '0;
      vld     <= '0;
      ptr     <= '0;
      lh_v    <= 1'b0;
      lh_idx  <= '0;
    end else begin
      lk_hit  <= lk_take;
      lk_miss <= lk_valid && !any_hit;
      lk_pa   <= lk_take ? {pa_pfn, lk_va[PG-1:0]} : '0;
      if (inv_all) begin
        vld  <= '0;
        lh_v <= 1'b0;
      end else begin
        if (lk_take) begin
          lh_v   <= 1'b1;
          lh_idx <= hit_idx;
        end
        if (fl_valid) begin
          vld[victim] <= 1'b1;
          if (!any_free) ptr <= next_slot(rr_victim);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (fl_valid && !inv_all) begin
      e_vpn[victim] <= fl_vpn;
      e_pfn[victim] <= fl_pfn;
      e_asn[victim] <= fl_asn;
      e_sz[victim]  <= fl_size;
    end
  end
endmodule

module va_xlat_tlb_chk #(
  parameter int PA_W    = 40,
  parameter int ENTRIES = 48
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       lk_valid,
  input logic [12:0]                lk_off,
  input logic                       lk_hit,
  input logic                       lk_miss,
  input logic [PA_W-1:0]            lk_pa,
  input logic                       fl_valid,
  input logic                       inv_all,
  input logic [ENTRIES-1:0]         vld,
  input logic [$clog2(ENTRIES)-1:0] victim,
  input logic [$clog2(ENTRIES)-1:0] eff_lh,
  input logic                       eff_lh_v,
  input logic                       any_free
);
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> (lk_hit ^ lk_miss)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !lk_valid |=> (!lk_hit && !lk_miss)); // R2
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n) lk_valid |=> (!lk_hit || lk_pa[12:0] == $past(lk_off))); // R4
  AST_MISS_PA_ZERO: assert property (@(posedge clk) disable iff (!rst_n) lk_miss |-> (lk_pa == '0)); // R4
  AST_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (fl_valid && !inv_all && any_free) |-> !vld[victim]); // R6
  AST_NLU_VICTIM: assert property (@(posedge clk) disable iff (!rst_n) (fl_valid && !inv_all && !any_free && eff_lh_v) |-> (victim != eff_lh)); // R8
  AST_FLUSH_ALL: assert property (@(posedge clk) disable iff (!rst_n) inv_all |=> (vld == '0)); // R10
endmodule

bind va_xlat_tlb va_xlat_tlb_chk #(.PA_W(PA_W), .ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_off(lk_va[12:0]),
  .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa), .fl_valid(fl_valid),
  .inv_all(inv_all), .vld(vld), .victim(victim), .eff_lh(eff_lh),
  .eff_lh_v(eff_lh_v), .any_free(any_free)
);

// File: tb/test_va_xlat_tlb.sv
module test_va_xlat_tlb;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, fl_valid = 0, inv_all = 0;
  logic [42:0] lk_va = '0;
  logic [6:0]  lk_asn = '0, fl_asn = '0;
  logic [29:0] fl_vpn = '0;
  logic [26:0] fl_pfn = '0;
  logic [1:0]  fl_size = '0;
  logic lk_hit, lk_miss;
  logic [39:0] lk_pa;

  always #4 clk = ~clk;

  va_xlat_tlb #(.ENTRIES(N)) i_va_xlat_tlb (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_va(lk_va), .lk_asn(lk_asn),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa(lk_pa), .fl_valid(fl_valid),
    .fl_vpn(fl_vpn), .fl_pfn(fl_pfn), .fl_asn(fl_asn), .fl_size(fl_size),
    .inv_all(inv_all));

  int checks = 0, fails = 0;
  bit done = 0;

  bit          mv   [N];
  logic [29:0] mvpn [N];
  logic [26:0] mpfn [N];
  logic [6:0]  masn [N];
  logic [1:0]  msz  [N];
  int mptr = 0, mlh = 0;
  bit mlhv = 0;

  function automatic int low_bits(input logic [1:0] s);
    return (1 << (3 * int'(s))) - 1;
  endfunction

  function automatic void model_look(input logic [42:0] va, input logic [6:0] asn,
                                     output bit h, output int idx, output logic [39:0] pa);
    h = 0; idx = 0; pa = '0;
    for (int i = 0; i < N; i++) begin
      if (!h && mv[i] && masn[i] == asn &&
          ((mvpn[i] ^ va[42:13]) & ~30'(low_bits(msz[i]))) == '0) begin
        h = 1; idx = i;
        pa = {(mpfn[i] & ~27'(low_bits(msz[i]))) | (va[39:13] & 27'(low_bits(msz[i]))), va[12:0]};
      end
    end
  endfunction

  task automatic cyc(input bit lv, input logic [42:0] va, input logic [6:0] asn,
                     input bit fv, input logic [29:0] vpn, input logic [26:0] pfn,
                     input logic [6:0] fasn, input logic [1:0] fsz, input bit inv,
                     input string tag);
    bit h, elhv, full;
    int idx, elh, vic;
    logic [39:0] pa;
    @(negedge clk);
    lk_valid = lv; lk_va = va; lk_asn = asn;
    fl_valid = fv; fl_vpn = vpn; fl_pfn = pfn; fl_asn = fasn; fl_size = fsz;
    inv_all = inv;
    model_look(va, asn, h, idx, pa);
    h = h && lv;
    elhv = h || mlhv;
    elh = h ? idx : mlh;
    full = 1; vic = 0;
    for (int i = N - 1; i >= 0; i--) if (!mv[i]) begin full = 0; vic = i; end
    if (inv) begin
      for (int i = 0; i < N; i++) mv[i] = 0;
      mlhv = 0;
    end else begin
      if (h) begin mlhv = 1; mlh = idx; end
      if (fv) begin
        if (full) begin
          vic = (elhv && mptr == elh) ? (mptr + 1) % N : mptr;
          mptr = (vic + 1) % N;
        end
        mv[vic] = 1; mvpn[vic] = vpn; mpfn[vic] = pfn; masn[vic] = fasn; msz[vic] = fsz;
      end
    end
    @(posedge clk);
    #1;
    checks++;
    if (lk_hit !== h || lk_miss !== (lv && !h) || lk_pa !== (h ? pa : 40'h0)) begin
      fails++;
      $display("FAIL %s: hit=%0b miss=%0b pa=%h expected hit=%0b miss=%0b pa=%h",
               tag, lk_hit, lk_miss, lk_pa, h, lv && !h, h ? pa : 40'h0);
    end
  endtask

  task automatic look(input logic [42:0] va, input logic [6:0] asn, input string tag);
    cyc(1, va, asn, 0, '0, '0, '0, 2'd0, 0, tag);
  endtask

  task automatic fill(input logic [29:0] vpn, input logic [26:0] pfn, input logic [6:0] asn,
                      input logic [1:0] sz, input string tag);
    cyc(0, '0, '0, 1, vpn, pfn, asn, sz, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    look(43'h0, 7'd0, "R1 empty table");
    cyc(0, 43'h1, '0, 0, '0, '0, '0, 2'd0, 0, "R2 idle cycle");

    fill(30'h100, 27'h5A5, 7'd3, 2'd0, "R6 first fill");
    look({30'h100, 13'h1ABC}, 7'd3, "R3 exact page hit");
    look({30'h100, 13'h1ABC}, 7'd4, "R3 context mismatch");
    look({30'h101, 13'h0000}, 7'd3, "R3 next page miss");

    fill(30'h4000, 27'h7F000, 7'd3, 2'd3, "R6 large fill");
    look({30'h41FF, 13'h1FFF}, 7'd3, "R5 R4 last page of 4MB");
    look({30'h4000, 13'h0000}, 7'd3, "R5 first page of 4MB");
    look({30'h4200, 13'h0000}, 7'd3, "R5 beyond 4MB");
    fill(30'h808, 27'h1230, 7'd3, 2'd1, "R6 64KB fill");
    look({30'h80F, 13'h0042}, 7'd3, "R5 R4 64KB passthrough");
    look({30'h810, 13'h0042}, 7'd3, "R5 beyond 64KB");

    cyc(1, {30'h777, 13'h10}, 7'd3, 1, 30'h777, 27'h333, 7'd3, 2'd0, 0, "R11 same-cycle fill");
    look({30'h777, 13'h10}, 7'd3, "R11 after fill");

    fill(30'h9000, 27'h111, 7'd5, 2'd2, "R6 overlap wide");
    fill(30'h9001, 27'h222, 7'd5, 2'd0, "R6 overlap narrow");
    look({30'h9001, 13'h5}, 7'd5, "R9 lowest index wins");

    for (int k = 0; k < 12; k++) begin
      fill(30'hA000 + 30'(k), 27'h400 + 27'(k), 7'd6, 2'd0, "R7 fill past full");
      look({30'hA000 + 30'(k), 13'h3}, 7'd6, "R8 hit newest");
      fill(30'hB000 + 30'(k), 27'h500 + 27'(k), 7'd6, 2'd0, "R8 fill after hit");
      look({30'hA000 + 30'(k), 13'h3}, 7'd6, "R8 hit slot survives");
    end
    for (int k = 0; k < 12; k++) begin
      look({30'hA000 + 30'(k), 13'h0}, 7'd6, "R7 survivor scan A");
      look({30'hB000 + 30'(k), 13'h0}, 7'd6, "R7 survivor scan B");
    end
    cyc(1, {30'hA00B, 13'h0}, 7'd6, 1, 30'hC000, 27'h9, 7'd6, 2'd0, 0, "R8 same-cycle hit and fill");
    look({30'hA00B, 13'h0}, 7'd6, "R8 same-cycle hit kept");

    cyc(0, '0, '0, 1, 30'hD000, 27'h1, 7'd1, 2'd0, 1, "R10 flush with fill");
    look({30'hD000, 13'h0}, 7'd1, "R10 fill dropped");
    look({30'hA00B, 13'h0}, 7'd6, "R10 old entry gone");
    fill(30'hE000, 27'h2, 7'd1, 2'd0, "R6 refill slot 0");
    look({30'hE000, 13'h0}, 7'd1, "R6 refill hit");

    for (int n = 0; n < 4000; n++) begin
      logic [29:0] vp;
      logic [42:0] va;
      logic [6:0] a;
      vp = {28'h0F00 + 28'($urandom % 4), 2'b00} ^ 30'($urandom % 512);
      va = {vp, 13'($urandom)};
      a  = 7'(1 + $urandom % 2);
      cyc(($urandom % 4) != 0, va, a, ($urandom % 3) == 0,
          {28'h0F00 + 28'($urandom % 4), 2'b00} ^ 30'($urandom % 512),
          27'($urandom), 7'(1 + $urandom % 2), 2'($urandom), ($urandom % 300) == 0,
          "R3 R4 R7 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule